// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a synchronous DRAM. After reset it raises the clock enable and waits a programmable settling time. It then runs a fixed start-up sequence on the command pins: one precharge of all banks, two auto-refresh commands, and a mode register write. Each command is followed by its recovery time in clock cycles. When the sequence is complete, the block reports that the device is ready for normal traffic.

After start-up, an interval counter builds up refresh debt at a fixed period. While refresh is owed, the block raises a request. An external access arbiter answers with a grant once it has finished its own work. The sequencer then closes every bank with a precharge-all, waits the precharge time, and issues the owed refresh commands back to back, spaced by the refresh recovery time. If the arbiter was late by one or more intervals, several refreshes are issued in one go. The debt saturates at a parameter limit.

All recovery times are integer parameters in clock cycles, each obtained by dividing the required time by the clock period and rounding up. The refresh interval is the retention period divided by the number of rows to refresh.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is asserted, `sd_cke`, `ready` and `ref_req` are low, and the command pins carry the no-op code.
- R2: From the first clock edge after reset is released, `sd_cke` is high, and it stays high.
- R3: The first command after reset is issued exactly `PWRUP_WAIT` cycles after reset release (the first edge with reset released counts as cycle 1).
- R4: The start-up order is precharge-all, refresh, refresh, mode register write. The spacings between them are `T_RP`, `T_RFC` and `T_RFC` cycles. The mode write drives `MODE_WORD` on the address pins and zero on the bank pins.
- R5: `ready` rises exactly `T_MRD` cycles after the mode register write.
- R6: Command codes on {cs_n, ras_n, cas_n, we_n}: mode write 0000, refresh 0001, precharge 0010, no-op 0111. Every cycle without a command carries the no-op code.
- R7: Every precharge drives address bit `AP_BIT` high, all other address bits low, and the bank pins to zero.
- R8: After start-up, one refresh becomes owed every `REF_INTERVAL` cycles. The first `ref_req` rise comes exactly `REF_INTERVAL` cycles after the first `ready` rise. `ref_req` is high only while `ready` is high.
- R9: A grant sampled while both `ready` and `ref_req` are high causes a precharge-all in the next cycle, and `ready` drops in that same cycle. The first refresh follows `T_RP` cycles later.
- R10: With one refresh owed, exactly one refresh is issued. `ready` returns `T_RFC` cycles after it.
- R11: With N ≥ 2 refreshes owed at grant time, N refreshes are issued back to back, `T_RFC` cycles apart.
- R12: The owed count saturates at `OWED_MAX`, so a very late grant yields exactly `OWED_MAX` refreshes.
- R13: A grant while no refresh is owed has no effect: `ready` stays high and only no-ops appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| ready | output | 1 | Start-up done and no refresh in progress |
| ref_req | output | 1 | Refresh owed, waiting for grant |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |

## Verification
On every cycle, the assertions check the following:
- `sd_cke` never falls after reset.
- Each precharge carries the all-banks bit.
- A refresh is followed by a no-op.
- The refresh debt never exceeds its limit and the interval counter never reaches zero.
- A grant with a request produces a precharge-all in the next cycle.
- A grant without a request leaves the block ready.

Only the directed scenarios can show the following:
- The exact cycle spacing of the start-up order.
- The mode word value.
- The arrival time of the first request.
- How many refreshes a late or very late grant produces.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_IPRE,
      ST_IREF,
      ST_IMRS,
      ST_IDLE,
      ST_PRE,
      ST_REF
   } seq_state_e;

   localparam int INIT_REFS = 2;

endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
   parameter int INTERVAL = 1562
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(INTERVAL + 1);

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(INTERVAL);
      end else if (en) begin
         cnt <= (cnt == CW'(1)) ? CW'(INTERVAL) : cnt - CW'(1);
      end
   end

   // R8
   interval_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);

endmodule

// File: rtl/sdram_ref_debt.sv
module sdram_ref_debt #(
   parameter int OWED_MAX = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          take,
   output logic [$clog2(OWED_MAX+1)-1:0] owed
);
   localparam int OW = $clog2(OWED_MAX + 1);

   logic [OW-1:0] base;

   always_comb begin
      base = take ? '0 : owed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed <= '0;
      end else if (tick && (base < OW'(OWED_MAX))) begin
         owed <= base + OW'(1);
      end else begin
         owed <= base;
      end
   end

   // R12
   owed_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owed <= OW'(OWED_MAX));

   // R12
   owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> (owed >= $past(owed)));

endmodule

// File: rtl/sdram_pin_map.sv
module sdram_pin_map
   import sdram_seq_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          BA_W      = 2,
   parameter int          AP_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
   input  sd_cmd_e           cmd,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] pre_all;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_ap
      if (i == AP_BIT) begin : g_on
         assign pre_all[i] = 1'b1;
      end else begin : g_off
         assign pre_all[i] = 1'b0;
      end
   end

   always_comb begin
      {cs_n, ras_n, cas_n, we_n} = cmd;
      ba = '0;
      unique case (cmd)
         CMD_PRE: addr = pre_all;
         CMD_MRS: addr = MODE_WORD;
         default: addr = '0;
      endcase
   end

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
   import sdram_seq_pkg::*;
#(
   parameter int          ADDR_W       = 12,
   parameter int          BA_W         = 2,
   parameter int          AP_BIT       = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032,
   parameter int          PWRUP_WAIT   = 20000,
   parameter int          T_RP         = 3,
   parameter int          T_RFC        = 8,
   parameter int          T_MRD        = 2,
   parameter int          REF_INTERVAL = 1562,
   parameter int          OWED_MAX     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_gnt,
   output logic              ready,
   output logic              ref_req,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr
);
   localparam int M1       = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int M2       = (M1 > T_MRD) ? M1 : T_MRD;
   localparam int WAIT_MAX = (M2 > PWRUP_WAIT) ? M2 : PWRUP_WAIT;
   localparam int WW       = $clog2(WAIT_MAX + 1);
   localparam int OW       = $clog2(OWED_MAX + 1);

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end
   if (T_RP < 1 || T_RFC < 1 || T_MRD < 1 || PWRUP_WAIT < 1) begin : g_bad_t
      $error("timing parameters must be at least one cycle");
   end
   if (REF_INTERVAL < 2) begin : g_bad_int
      $error("REF_INTERVAL must be at least two cycles");
   end
   if (OWED_MAX < INIT_REFS) begin : g_bad_owed
      $error("OWED_MAX must allow a two-refresh catch-up");
   end

   seq_state_e    state;
   sd_cmd_e       cmd_q;
   logic [WW-1:0] wcnt;
   logic [OW-1:0] left;
   logic [OW-1:0] owed;
   logic          cke_q;
   logic          init_done;
   logic          tick;
   logic          take;
   logic          last;

   assign ready   = (state == ST_IDLE);
   assign ref_req = ready && (owed != '0);
   assign take    = ref_req && ref_gnt;
   assign last    = (wcnt == WW'(1));
   assign sd_cke  = cke_q;

   sdram_ref_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (init_done),
      .tick (tick)
   );

   sdram_ref_debt #(.OWED_MAX(OWED_MAX)) u_debt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .take (take),
      .owed (owed)
   );

   sdram_pin_map #(
      .ADDR_W   (ADDR_W),
      .BA_W     (BA_W),
      .AP_BIT   (AP_BIT),
      .MODE_WORD(MODE_WORD)
   ) u_pins (
      .cmd  (cmd_q),
      .cs_n (sd_cs_n),
      .ras_n(sd_ras_n),
      .cas_n(sd_cas_n),
      .we_n (sd_we_n),
      .ba   (sd_ba),
      .addr (sd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_PWR;
         cmd_q     <= CMD_NOP;
         wcnt      <= WW'(PWRUP_WAIT);
         left      <= '0;
         cke_q     <= 1'b0;
         init_done <= 1'b0;
      end else begin
         cke_q <= 1'b1;
         cmd_q <= CMD_NOP;
         unique case (state)
            ST_PWR: begin
               if (last) begin
                  cmd_q <= CMD_PRE;
                  wcnt  <= WW'(T_RP);
                  state <= ST_IPRE;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            ST_IPRE: begin
               if (last) begin
                  cmd_q <= CMD_REF;
                  wcnt  <= WW'(T_RFC);
                  left  <= OW'(INIT_REFS - 1);
                  state <= ST_IREF;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            ST_IREF: begin
               if (last && left != '0) begin
                  cmd_q <= CMD_REF;
                  wcnt  <= WW'(T_RFC);
                  left  <= left - OW'(1);
               end else if (last) begin
                  cmd_q <= CMD_MRS;
                  wcnt  <= WW'(T_MRD);
                  state <= ST_IMRS;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            ST_IMRS: begin
               if (last) begin
                  wcnt      <= '0;
                  init_done <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            ST_IDLE: begin
               if (take) begin
                  cmd_q <= CMD_PRE;
                  wcnt  <= WW'(T_RP);
                  left  <= owed;
                  state <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (last) begin
                  cmd_q <= CMD_REF;
                  wcnt  <= WW'(T_RFC);
                  left  <= left - OW'(1);
                  state <= ST_REF;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            ST_REF: begin
               if (last && left != '0) begin
                  cmd_q <= CMD_REF;
                  wcnt  <= WW'(T_RFC);
                  left  <= left - OW'(1);
               end else if (last) begin
                  wcnt  <= '0;
                  state <= ST_IDLE;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sd_cke));

   // R7
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) |-> sd_addr[AP_BIT]);

   // R8
   req_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> ready);

   // R9
   grant_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ref_req && ref_gnt) |=>
         ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) && !ready);

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !ref_req) |=> ready);

   if (T_RFC > 1) begin : g_rfc_gap
      // R11
      ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) |=>
            ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));
   end

endmodule

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;
   localparam int          ADDR_W = 12;
   localparam int          BA_W   = 2;
   localparam int          AP     = 10;
   localparam logic [11:0] MODE   = 12'h022;
   localparam int          PW     = 12;
   localparam int          TRP    = 3;
   localparam int          TRFC   = 8;
   localparam int          TMRD   = 2;
   localparam int          INTV   = 100;
   localparam int          OMAX   = 4;

   localparam logic [3:0] C_MRS = 4'b0000;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_NOP = 4'b0111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic ready, ref_req, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [BA_W-1:0]   sd_ba;
   logic [ADDR_W-1:0] sd_addr;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int rel_cyc = 0;
   int rdy_cyc = 0;

   sdram_refresh_seq #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP), .MODE_WORD(MODE),
      .PWRUP_WAIT(PW), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
      .REF_INTERVAL(INTV), .OWED_MAX(OMAX)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ready(ready), .ref_req(ref_req),
      .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [3:0] pins();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_cmd(input int limit, output logic [3:0] c, output int at,
                           output logic [ADDR_W-1:0] a, output logic [BA_W-1:0] b);
      bit found = 0;
      c = C_NOP; at = -1; a = '0; b = '0;
      for (int i = 0; i < limit && !found; i++) begin
         @(negedge clk);
         if (pins() != C_NOP) begin
            c = pins(); at = cyc; a = sd_addr; b = sd_ba; found = 1;
         end
      end
   endtask

   task automatic wait_req(input int limit, output int at);
      at = -1;
      for (int i = 0; i < limit && at < 0; i++) begin
         @(negedge clk);
         if (ref_req) at = cyc;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk(sd_cke == 1'b0 && ready == 1'b0 && ref_req == 1'b0, "R1", "cke/ready/req in reset",
          {sd_cke, ready, ref_req}, 0);
      // R6
      chk(pins() == C_NOP, "R6", "command pins in reset", pins(), C_NOP);
      rel_cyc = cyc;
      rst_n = 1'b1;
      @(negedge clk);
      // R2
      chk(sd_cke == 1'b1, "R2", "cke after first edge", sd_cke, 1);
   endtask

   task automatic t_init();
      logic [3:0] c; int at, prev; logic [ADDR_W-1:0] a; logic [BA_W-1:0] b;
      next_cmd(PW + 20, c, at, a, b);
      // R3 R6
      chk(c == C_PRE, "R6", "first command code", c, C_PRE);
      chk(at == rel_cyc + PW, "R3", "first command cycle", at - rel_cyc, PW);
      // R7
      chk(a == (ADDR_W'(1) << AP) && b == '0, "R7", "precharge address", a, 1 << AP);
      prev = at;
      for (int k = 0; k < 2; k++) begin
         next_cmd(TRFC + 20, c, at, a, b);
         chk(c == C_REF, "R4", "init refresh code", c, C_REF);
         chk(at - prev == (k == 0 ? TRP : TRFC), "R4", "init refresh spacing",
             at - prev, (k == 0 ? TRP : TRFC));
         prev = at;
      end
      next_cmd(TRFC + 20, c, at, a, b);
      chk(c == C_MRS, "R4", "mode write code", c, C_MRS);
      chk(at - prev == TRFC, "R4", "mode write spacing", at - prev, TRFC);
      chk(a == MODE && b == '0, "R4", "mode word", a, MODE);
      rdy_cyc = -1;
      for (int i = 0; i < 40 && rdy_cyc < 0; i++) begin
         @(negedge clk);
         if (ready) rdy_cyc = cyc;
      end
      // R5
      chk(rdy_cyc - at == TMRD, "R5", "ready after mode write", rdy_cyc - at, TMRD);
   endtask

   task automatic run_refresh(input int n, input string req);
      logic [3:0] c; int at, prev, g, rise, extra; logic [ADDR_W-1:0] a; logic [BA_W-1:0] b;
      g = cyc;
      ref_gnt = 1'b1;
      next_cmd(4, c, at, a, b);
      ref_gnt = 1'b0;
      // R9
      chk(c == C_PRE && at == g + 1, "R9", "precharge after grant", at - g, 1);
      chk(ready == 1'b0, "R9", "ready during refresh", ready, 0);
      chk(a[AP] == 1'b1, "R7", "refresh precharge all bit", a[AP], 1);
      prev = at;
      for (int k = 0; k < n; k++) begin
         next_cmd(TRFC + 20, c, at, a, b);
         chk(c == C_REF, req, "refresh code", c, C_REF);
         chk(at - prev == (k == 0 ? TRP : TRFC), req, "refresh spacing", at - prev,
             (k == 0 ? TRP : TRFC));
         prev = at;
      end
      rise = -1; extra = 0;
      for (int i = 0; i < TRFC + 20 && rise < 0; i++) begin
         @(negedge clk);
         if (pins() != C_NOP) extra++;
         if (ready) rise = cyc;
      end
      chk(extra == 0, req, "extra refreshes", n + extra, n);
      chk(rise - prev == TRFC, req, "ready after last refresh", rise - prev, TRFC);
   endtask

   task automatic t_single();
      int rq;
      wait_req(3 * INTV, rq);
      // R8
      chk(rq == rdy_cyc + INTV, "R8", "first request cycle", rq - rdy_cyc, INTV);
      chk(ready == 1'b1, "R8", "ready with request", ready, 1);
      // R10
      run_refresh(1, "R10");
   endtask

   task automatic t_late();
      int rq;
      wait_req(3 * INTV, rq);
      repeat (INTV + 1) @(negedge clk);
      // R11
      run_refresh(2, "R11");
   endtask

   task automatic t_ignore();
      bit ok = 1;
      chk(ref_req == 1'b0, "R13", "no request before stray grant", ref_req, 0);
      ref_gnt = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!ready || pins() != C_NOP) ok = 0;
      end
      ref_gnt = 1'b0;
      // R13
      chk(ok, "R13", "stray grant ignored", ok, 1);
   endtask

   task automatic t_sat();
      int rq;
      wait_req(3 * INTV, rq);
      repeat (5 * INTV + 1) @(negedge clk);
      // R12
      run_refresh(OMAX, "R12");
      chk(sd_cke == 1'b1, "R2", "cke still high", sd_cke, 1);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_init();
      t_single();
      t_late();
      t_ignore();
      t_sat();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule